// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Read Target

This block is the read side of an 8K x 8 serial EEPROM that answers on a two-wire (I2C) bus. It samples SCL and SDA with a fast system clock and finds Start and Stop conditions in the sampled lines. It decodes the select byte and acknowledges when the byte addresses this device. It pulls SDA low through an open-drain enable and never drives it high.

A 13-bit address counter is shared by every transaction and is kept between transactions. A write-mode select followed by two address bytes loads the counter. This is a dummy write: the master sends no data, issues a repeated Start, and reads from the loaded address. A read-mode select alone reads from wherever the counter stands. Every byte sent moves the counter up by one. The counter wraps from its top value to zero. A master acknowledge asks for the next byte. A missing acknowledge ends the stream.

A second device type routes reads to a 32-byte identification page, indexed by the low five counter bits. While `id_locked` is high, that page reads as FFh. Both stores are synchronous RAMs that are filled through a preload port. The main array keeps 2^MEM_AW bytes. Counter values above that range alias onto it.

Top module: `i2c_eeprom_rd`

## Requirements
- R1: After reset SDA is released. A select byte is acknowledged only when bits 7:4 are 1010b (array) or 1011b (identification page) and bits 3:1 equal `ce`. Bit 0 is the RW bit, with 1 meaning read. Any other select byte gets no acknowledge and leaves the counter unchanged.
- R2: A write-mode select, a high address byte and a low address byte, followed by a repeated Start and a read-mode select, returns the byte stored at that address.
- R3: While the master acknowledges each byte, the block sends the bytes at consecutive addresses.
- R4: A read-mode select with no address phase returns the byte at the address that follows the last byte sent, across Stop conditions.
- R5: After address 1FFFh the counter wraps to 0000h and output continues from there.
- R6: A read with device type 1011b returns identification page byte `cnt[4:0]`. Counter bits above bit 4 have no effect on which byte is read.
- R7: While `id_locked` is high, every identification page byte reads as FFh.
- R8: After the master leaves a data byte unacknowledged, SDA stays released for any further clock pulses until the next Start.
- R9: A Stop or Start in the middle of a byte aborts the transfer, releases SDA and leaves the counter unchanged.
- R10: SDA is released during the master's acknowledge bit.
- R11: Both address bytes are acknowledged and their low 13 bits load the counter. Further bytes written after the low address byte are not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock as seen on the wire |
| sda_i | input | 1 | Bus data as seen on the wire |
| sda_oe | output | 1 | Pull SDA low when high (open-drain) |
| ce | input | 3 | Chip-enable strap compared with select bits 3:1 |
| id_locked | input | 1 | Identification page locked; its bytes read as FFh |
| ld_en | input | 1 | Preload write strobe |
| ld_id | input | 1 | Preload target: 1 = identification page, 0 = array |
| ld_addr | input | MEM_AW | Preload address (low 5 bits for the page) |
| ld_data | input | 8 | Preload data |

## Verification
The assertions assume a well-formed bus. SCL is slow enough that each level lasts many system clocks. The master changes SDA only while SCL is low, except when it makes a Start or a Stop, and it releases SDA whenever the target may drive. The bench master holds every SCL and SDA phase for ten system clocks and drives only on falling clock edges. It sends a Stop or Start in the middle of a byte only in the abort cases, and only while SCL is low. The preload happens before any bus traffic.

// File: rtl/i2c_rd_pkg.sv
package i2c_rd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_AHI, ST_ALO, ST_ACK, ST_TX, ST_MACK, ST_WAIT
  } rd_state_t;
  localparam logic [3:0] TYPE_MEM = 4'b1010;
  localparam logic [3:0] TYPE_ID  = 4'b1011;
endpackage

// File: rtl/i2c_bus_sampler.sv
module i2c_bus_sampler #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p
);
  logic [SYNC-1:0] scl_sh, sda_sh;
  logic scl_q, sda_q, scl_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC-2:0], scl_i};
      sda_sh <= {sda_sh[SYNC-2:0], sda_i};
      scl_q  <= scl_sh[SYNC-1];
      sda_q  <= sda_sh[SYNC-1];
    end
  end

  assign scl_n    = scl_sh[SYNC-1];
  assign sda_s    = sda_sh[SYNC-1];
  assign scl_rise = scl_n & ~scl_q;
  assign scl_fall = ~scl_n & scl_q;
  assign start_p  = scl_n & scl_q & sda_q & ~sda_s;
  assign stop_p   = scl_n & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_rd_mem.sv
module i2c_rd_mem #(
  parameter int MEM_AW = 11,
  parameter int ID_AW  = 5
) (
  input  logic              clk,
  input  logic              ld_en,
  input  logic              ld_id,
  input  logic [MEM_AW-1:0] ld_addr,
  input  logic [7:0]        ld_data,
  input  logic [MEM_AW-1:0] mem_addr,
  input  logic [ID_AW-1:0]  id_addr,
  input  logic              id_sel,
  input  logic              id_locked,
  output logic [7:0]        rdata
);
  localparam int MEM_DEPTH = 1 << MEM_AW;
  localparam int ID_DEPTH  = 1 << ID_AW;

  logic [7:0] arr [MEM_DEPTH];
  logic [7:0] idp [ID_DEPTH];
  logic [7:0] arr_q, idp_q;
  logic       sel_q, lock_q;

  always_ff @(posedge clk) begin
    if (ld_en && !ld_id) arr[ld_addr] <= ld_data;
    arr_q <= arr[mem_addr];
  end

  always_ff @(posedge clk) begin
    if (ld_en && ld_id) idp[ld_addr[ID_AW-1:0]] <= ld_data;
    idp_q  <= idp[id_addr];
    sel_q  <= id_sel;
    lock_q <= id_locked;
  end

  assign rdata = !sel_q ? arr_q : (lock_q ? 8'hFF : idp_q);
endmodule

// File: rtl/i2c_rd_fsm.sv
module i2c_rd_fsm
  import i2c_rd_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_p,
  input  logic              stop_p,
  input  logic [2:0]        ce,
  input  logic [7:0]        rdata,
  output logic              sda_oe,
  output logic              id_sel,
  output logic [ADDR_W-1:0] cnt
);
  rd_state_t  st, ret;
  logic [2:0] bits;
  logic [7:0] sh, hi_q, tx_sh;
  logic       got8, mack_ok;
  logic       sel_hit;

  assign sel_hit = (sh[7:4] == TYPE_MEM || sh[7:4] == TYPE_ID) && (sh[3:1] == ce);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; ret <= ST_WAIT; bits <= '0; sh <= '0; hi_q <= '0;
      tx_sh <= '0; got8 <= 1'b0; mack_ok <= 1'b0; sda_oe <= 1'b0;
      id_sel <= 1'b0; cnt <= '0;
    end else if (stop_p) begin
      st <= ST_IDLE;
      sda_oe <= 1'b0;
    end else if (start_p) begin
      st <= ST_DEV; bits <= '0; got8 <= 1'b0; sda_oe <= 1'b0;
    end else begin
      case (st)
        ST_DEV, ST_AHI, ST_ALO: begin
          if (scl_rise && !got8) begin
            sh   <= {sh[6:0], sda_s};
            got8 <= (bits == 3'd7);
            bits <= bits + 3'd1;
          end else if (scl_fall && got8) begin
            got8 <= 1'b0;
            bits <= '0;
            if (st == ST_DEV) begin
              if (sel_hit) begin
                sda_oe <= 1'b1;
                st     <= ST_ACK;
                id_sel <= (sh[7:4] == TYPE_ID);
                ret    <= sh[0] ? ST_TX : ST_AHI;
              end else begin
                st <= ST_WAIT;
              end
            end else if (st == ST_AHI) begin
              hi_q <= sh; sda_oe <= 1'b1; st <= ST_ACK; ret <= ST_ALO;
            end else begin
              cnt <= ADDR_W'({hi_q, sh}); sda_oe <= 1'b1; st <= ST_ACK; ret <= ST_WAIT;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            bits <= '0;
            got8 <= 1'b0;
            if (ret == ST_TX) begin
              tx_sh  <= rdata;
              sda_oe <= ~rdata[7];
            end else begin
              sda_oe <= 1'b0;
            end
            st <= ret;
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bits == 3'd7) begin
              sda_oe <= 1'b0;
              st     <= ST_MACK;
              cnt    <= cnt + 1'b1;
            end else begin
              tx_sh  <= {tx_sh[6:0], 1'b0};
              sda_oe <= ~tx_sh[6];
              bits   <= bits + 3'd1;
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) mack_ok <= ~sda_s;
          else if (scl_fall) begin
            if (mack_ok) begin
              tx_sh  <= rdata;
              sda_oe <= ~rdata[7];
              bits   <= '0;
              st     <= ST_TX;
            end else begin
              st <= ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R9
  stop_idle_chk: assert property (@(posedge clk) disable iff (rst)
    stop_p |=> (st == ST_IDLE) && !sda_oe);
  // R10
  mack_release_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_MACK) |-> !sda_oe);
  // R1
  drive_window_chk: assert property (@(posedge clk) disable iff (rst)
    sda_oe |-> (st == ST_ACK || st == ST_TX));
  // R4
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(st == ST_ALO || st == ST_TX) |=> $stable(cnt));
  // R8
  wait_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAIT) |-> !sda_oe);
endmodule

// File: rtl/i2c_eeprom_rd.sv
module i2c_eeprom_rd #(
  parameter int ADDR_W = 13,
  parameter int MEM_AW = 11,
  parameter int ID_AW  = 5,
  parameter int SYNC   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [2:0]        ce,
  input  logic              id_locked,
  input  logic              ld_en,
  input  logic              ld_id,
  input  logic [MEM_AW-1:0] ld_addr,
  input  logic [7:0]        ld_data
);
  logic              sda_s, scl_rise, scl_fall, start_p, stop_p, id_sel;
  logic [ADDR_W-1:0] cnt;
  logic [7:0]        rdata;

  i2c_bus_sampler #(.SYNC(SYNC)) u_smp (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_p(start_p), .stop_p(stop_p)
  );

  i2c_rd_mem #(.MEM_AW(MEM_AW), .ID_AW(ID_AW)) u_mem (
    .clk(clk), .ld_en(ld_en), .ld_id(ld_id), .ld_addr(ld_addr), .ld_data(ld_data),
    .mem_addr(cnt[MEM_AW-1:0]), .id_addr(cnt[ID_AW-1:0]), .id_sel(id_sel),
    .id_locked(id_locked), .rdata(rdata)
  );

  i2c_rd_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_p(start_p), .stop_p(stop_p), .ce(ce), .rdata(rdata),
    .sda_oe(sda_oe), .id_sel(id_sel), .cnt(cnt)
  );
endmodule

// File: tb/i2c_eeprom_rd_tb.sv
module i2c_eeprom_rd_tb;
  localparam int MEM_AW = 11;
  localparam int Q = 10;

  typedef struct { logic [7:0] val; string tag; } exp_t;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1, scl_m = 1'b1, sda_m = 1'b1, id_locked = 1'b0;
  logic ld_en = 1'b0, ld_id = 1'b0;
  logic [MEM_AW-1:0] ld_addr = '0;
  logic [7:0] ld_data = '0;
  logic [2:0] ce = 3'b101;
  logic sda_oe;
  wire  sda_line = sda_m & ~sda_oe;

  int checks = 0, errors = 0;
  bit done = 0;
  exp_t exp_q[$];
  logic [7:0] got;
  event byte_ev;

  i2c_eeprom_rd u_dut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .ce(ce), .id_locked(id_locked), .ld_en(ld_en), .ld_id(ld_id),
    .ld_addr(ld_addr), .ld_data(ld_data)
  );

  function automatic logic [7:0] memv(int a);
    int m = a % (1 << MEM_AW);
    return 8'(m * 7 + 3) ^ 8'(m >> 3);
  endfunction
  function automatic logic [7:0] idv(int i);
    return 8'h5C ^ 8'(i * 13);
  endfunction

  task automatic check(string tag, int act, int expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic hold(); repeat (Q) @(negedge clk); endtask
  task automatic bus_start(); sda_m = 1; hold(); scl_m = 1; hold(); sda_m = 0; hold(); scl_m = 0; hold(); endtask
  task automatic bus_stop(); sda_m = 0; hold(); scl_m = 1; hold(); sda_m = 1; hold(); endtask
  task automatic put_bit(logic b); sda_m = b; hold(); scl_m = 1; hold(); hold(); scl_m = 0; hold(); endtask
  task automatic get_bit(output logic b); sda_m = 1; hold(); scl_m = 1; hold(); b = sda_line; hold(); scl_m = 0; hold(); endtask

  task automatic send_byte(logic [7:0] d, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(a);
    ack = ~a;
  endtask

  // monitor side: the driver pushes expectations, the byte receiver raises byte_ev
  task automatic recv_byte(logic mack);
    logic b;
    logic [7:0] d;
    for (int i = 7; i >= 0; i--) begin get_bit(b); d[i] = b; end
    sda_m = ~mack; hold(); scl_m = 1; hold();
    check("R10 release in master ack", sda_oe, 0);
    hold(); scl_m = 0; hold(); sda_m = 1;
    got = d;
    ->byte_ev;
    @(negedge clk);
  endtask

  always @(byte_ev) begin
    exp_t e;
    if (exp_q.size() == 0) check("scoreboard underflow", 1, 0);
    else begin
      e = exp_q.pop_front();
      check(e.tag, got, e.val);
    end
  end

  task automatic expect_ack(string tag, logic [7:0] d, logic want);
    logic a;
    send_byte(d, a);
    check(tag, a, want);
  endtask

  task automatic set_addr(int a);
    bus_start();
    expect_ack("R1 write select", 8'hAA, 1);
    expect_ack("R11 high address", 8'(a >> 8), 1);
    expect_ack("R11 low address", 8'(a), 1);
  endtask

  task automatic read_n(logic [7:0] sel, int n);
    expect_ack("R1 read select", sel, 1);
    for (int i = 0; i < n; i++) recv_byte(i != n - 1);
    bus_stop();
  endtask

  task automatic push(logic [7:0] v, string tag);
    exp_t e; e.val = v; e.tag = tag; exp_q.push_back(e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic b;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 reset release", sda_oe, 0);
    for (int i = 0; i < (1 << MEM_AW); i++) begin
      ld_en = 1; ld_id = 0; ld_addr = MEM_AW'(i); ld_data = memv(i); @(negedge clk);
    end
    for (int i = 0; i < 32; i++) begin
      ld_id = 1; ld_addr = MEM_AW'(i); ld_data = idv(i); @(negedge clk);
    end
    ld_en = 0; ld_id = 0;

    // R2 random read
    set_addr(16'h0123); bus_start();
    push(memv(16'h123), "R2 random read"); read_n(8'hAB, 1);
    // R4 current read continues
    bus_start(); push(memv(16'h124), "R4 current read"); read_n(8'hAB, 1);
    // R3 sequential
    bus_start();
    for (int i = 0; i < 4; i++) push(memv(16'h125 + i), "R3 sequential");
    read_n(8'hAB, 4);
    // R5 wrap
    set_addr(16'h1FFE); bus_start();
    push(memv(16'h7FE), "R5 before wrap"); push(memv(16'h7FF), "R5 top");
    push(memv(0), "R5 wrapped"); push(memv(1), "R5 after wrap");
    read_n(8'hAB, 4);
    // R1 wrong strap and wrong type
    bus_start(); expect_ack("R1 wrong ce", 8'hA3, 0); bus_stop();
    bus_start(); expect_ack("R1 wrong type", 8'h9B, 0); bus_stop();
    bus_start(); push(memv(2), "R1 counter kept"); read_n(8'hAB, 1);
    // R6 identification page, high bits ignored (E5 -> 05)
    set_addr(16'h1FE5); bus_start();
    push(idv(5), "R6 id page"); push(idv(6), "R6 id page next");
    read_n(8'hBB, 2);
    // R7 locked
    id_locked = 1;
    bus_start(); push(8'hFF, "R7 locked"); push(8'hFF, "R7 locked next"); read_n(8'hBB, 2);
    id_locked = 0;
    // R8 nack then extra clocks: stays released
    bus_start(); push(memv(16'h7E9), "R8 last byte"); expect_ack("R1 read select", 8'hAB, 1);
    recv_byte(0);
    get_bit(b); check("R8 released after nack", b, 1);
    get_bit(b); check("R8 released after nack", b, 1);
    bus_stop();
    // R11 data after address not acknowledged, address loaded
    set_addr(16'h0040);
    expect_ack("R11 write data ignored", 8'h55, 0);
    bus_stop();
    bus_start(); push(memv(16'h40), "R11 address loaded"); read_n(8'hAB, 1);
    // R9 stop mid-byte
    bus_start(); expect_ack("R1 write select", 8'hAA, 1);
    put_bit(0); put_bit(1); put_bit(1); put_bit(0);
    bus_stop();
    check("R9 stop abort release", sda_oe, 0);
    bus_start(); push(memv(16'h41), "R9 stop abort counter"); read_n(8'hAB, 1);
    // R9 start mid-byte
    bus_start(); expect_ack("R1 write select", 8'hAA, 1);
    put_bit(1); put_bit(0); put_bit(1);
    bus_start(); push(memv(16'h42), "R9 start abort counter"); read_n(8'hAB, 1);

    repeat (20) @(negedge clk);
    check("scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule